// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block catches software that has stopped running its intended sequence. A free-running prescaler divides the peripheral clock. Its rollover pulses decrement a 12-bit down counter. The counter starts at all ones. Healthy software writes the watchdog register from time to time, and each write brings the counter back to all ones. If no write arrives in time, the counter's top bit would drop to zero. At that point the block reloads the counter by itself and raises a sticky interrupt request. The request stays up until software clears it.

Software picks one of two step rates with a select bit. The fast rate is one step per 16 clocks and the slow rate is one step per 256 clocks. Entering stop mode forces the fast rate. Counting pauses while the system is in wait mode, while it is in stop mode, and while it makes an external access during hold. The present count comes out on a read-only port.

Top module: `rwd_top`

## Requirements
- R1: After reset the count is 0xFFF, the interrupt flag is 0 and the select bit is 0, which selects the slow rate.
- R2: With the select bit at 1, the counter drops by one once every 16 clocks. The prescaler is cleared by reset, so the first step lands on the 16th rising edge after reset is released.
- R3: With the select bit at 0, the counter drops by one once every 256 clocks, on the edges where all 8 prescaler bits roll over.
- R4: A step that would take the count from 0x800 to 0x7FF loads 0xFFF instead and sets the interrupt flag. This is the 2048th step after a load of 0xFFF, and bit 11 of the count is never seen at 0.
- R5: A pulse on the reload strobe loads 0xFFF on the next edge. A reload that falls in the same cycle as a step wins, and in that case the flag is not set.
- R6: A stop-entry pulse loads 0xFFF and sets the select bit to 1. It also wins over a select write in the same cycle.
- R7: A step is dropped in any cycle where waitMode, stopMode or holdExtAccess is high. The prescaler keeps running during these cycles.
- R8: The interrupt flag stays at 1 until an irqClr pulse clears it. If a clear and a timeout fall in the same cycle, the flag stays at 1.
- R9: A pulse on selWr loads selData into the select bit, and selFast shows the value of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reloadWr | input | 1 | Write strobe for the watchdog register; causes a reload |
| selWr | input | 1 | Write strobe for the select bit |
| selData | input | 1 | Value written to the select bit (1 = fast) |
| stopEntry | input | 1 | Pulse marking execution of the stop instruction |
| waitMode | input | 1 | System is in wait mode |
| stopMode | input | 1 | System is in stop mode |
| holdExtAccess | input | 1 | External access while the bus is held |
| irqClr | input | 1 | Clear strobe for the interrupt flag |
| irqFlag | output | 1 | Sticky timeout interrupt request |
| selFast | output | 1 | Current value of the select bit |
| count | output | 12 | Current counter value |

## Verification
The assertions assume that strobes are synchronous, one-clock pulses and that reset is released away from a clock edge. They also assume that the fast rate never produces a step on two edges in a row. The bench changes inputs only on falling edges and holds each strobe for exactly one cycle. It lines up the tests for reload-versus-step and clear-versus-timeout by following the prescaler phase it counts from reset, so these collisions land on the exact step edge.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic countEn;  // one prescaled step
    logic reload;   // load all ones
  } rwd_strobe_t;
endpackage

// File: rtl/rwd_ctrl.sv
module rwd_ctrl
  import rwd_pkg::*;
#(
  parameter int FAST_LOG2 = 4,
  parameter int SLOW_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reloadWr,
  input  logic        selWr,
  input  logic        selData,
  input  logic        stopEntry,
  input  logic        waitMode,
  input  logic        stopMode,
  input  logic        holdExtAccess,
  output logic        selFast,
  output rwd_strobe_t strobe
);
  localparam int PRE_W = SLOW_LOG2;

  logic [PRE_W-1:0] preCnt;
  logic             selBit;
  logic             fastTick;
  logic             slowTick;
  logic             suspend;

  // free-running prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign fastTick = &preCnt[FAST_LOG2-1:0];
  assign slowTick = &preCnt;

  // select bit: stop entry forces the fast rate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          selBit <= 1'b0;
    else if (stopEntry) selBit <= 1'b1;
    else if (selWr)     selBit <= selData;
  end

  assign suspend        = waitMode | stopMode | holdExtAccess;
  assign strobe.countEn = (selBit ? fastTick : slowTick) & ~suspend;
  assign strobe.reload  = reloadWr | stopEntry;
  assign selFast        = selBit;

  p_stop_fast_r6: assert property (@(posedge clk) disable iff (!rstN)
    stopEntry |=> selBit);
  p_sel_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (selWr && !stopEntry) |=> (selBit == $past(selData)));
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |=> !strobe.countEn);
  p_suspend_r7: assert property (@(posedge clk) disable iff (!rstN)
    (waitMode || stopMode || holdExtAccess) |-> !strobe.countEn);
endmodule

// File: rtl/rwd_datapath.sv
module rwd_datapath
  import rwd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  rwd_strobe_t      strobe,
  input  logic             irqClr,
  output logic [CNT_W-1:0] count,
  output logic             irqFlag
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] EDGE = {1'b1, {(CNT_W-1){1'b0}}};

  logic timeout;

  assign timeout = strobe.countEn & ~strobe.reload & (count == EDGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          count <= FULL;
    else if (strobe.reload || timeout)  count <= FULL;
    else if (strobe.countEn)            count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        irqFlag <= 1'b0;
    else if (timeout) irqFlag <= 1'b1;
    else if (irqClr)  irqFlag <= 1'b0;
  end

  p_reload_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (count == FULL));
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.reload && count != EDGE) |=> (count == $past(count) - 1'b1));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.reload) |=> $stable(count));
  p_msb_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    count[CNT_W-1]);
  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.reload && count == EDGE) |=> (irqFlag && count == FULL));
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);
endmodule

// File: rtl/rwd_top.sv
module rwd_top
  import rwd_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int FAST_LOG2 = 4,
  parameter int SLOW_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reloadWr,
  input  logic             selWr,
  input  logic             selData,
  input  logic             stopEntry,
  input  logic             waitMode,
  input  logic             stopMode,
  input  logic             holdExtAccess,
  input  logic             irqClr,
  output logic             irqFlag,
  output logic             selFast,
  output logic [CNT_W-1:0] count
);
  rwd_strobe_t strobe;

  rwd_ctrl #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) i_ctrl (
    .clk(clk), .rstN(rstN), .reloadWr(reloadWr), .selWr(selWr),
    .selData(selData), .stopEntry(stopEntry), .waitMode(waitMode),
    .stopMode(stopMode), .holdExtAccess(holdExtAccess),
    .selFast(selFast), .strobe(strobe)
  );

  rwd_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqClr(irqClr),
    .count(count), .irqFlag(irqFlag)
  );
endmodule

// File: tb/test_rwd_top.sv
`timescale 1ns/1ps
module test_rwd_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reloadWr = 0, selWr = 0, selData = 0, stopEntry = 0;
  logic waitMode = 0, stopMode = 0, holdExtAccess = 0, irqClr = 0;
  logic irqFlag, selFast;
  logic [11:0] count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int msbErrors = 0;

  // reference state, derived from the requirements
  logic [7:0]  mPhase;
  logic [11:0] mCnt;
  logic        mIrq;
  logic        mSel;

  always #2 clk = ~clk;

  rwd_top i_rwd_top (
    .clk(clk), .rstN(rstN), .reloadWr(reloadWr), .selWr(selWr),
    .selData(selData), .stopEntry(stopEntry), .waitMode(waitMode),
    .stopMode(stopMode), .holdExtAccess(holdExtAccess), .irqClr(irqClr),
    .irqFlag(irqFlag), .selFast(selFast), .count(count)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d cycles expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // R4: bit 11 of the count must never be seen low
  always @(negedge clk) if (rstN && !count[11]) msbErrors++;

  // table: {cycles[15:0], sel, wait, stop, hold}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {16'd100,  4'b1000},  // R2 fast rate
    {16'd600,  4'b0000},  // R3 slow rate
    {16'd200,  4'b1100},  // R7 wait
    {16'd200,  4'b1010},  // R7 stop mode
    {16'd200,  4'b1001},  // R7 hold access
    {16'd300,  4'b1000},  // R2 fast again
    {16'd1000, 4'b0100},  // R7 wait, slow
    {16'd520,  4'b0000}   // R3 slow again
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mPhase = '0; mCnt = 12'hFFF; mIrq = 0; mSel = 0;
  endtask

  // one clock; inputs are already set; model follows the requirements
  task automatic tick();
    logic step, tmo;
    @(posedge clk);
    step = (mSel ? (mPhase[3:0] == 4'hF) : (mPhase == 8'hFF))
           && !(waitMode || stopMode || holdExtAccess);
    tmo = step && !(reloadWr || stopEntry) && mCnt == 12'h800;
    if (reloadWr || stopEntry || tmo) mCnt = 12'hFFF;
    else if (step) mCnt = mCnt - 1'b1;
    if (tmo) mIrq = 1;
    else if (irqClr) mIrq = 0;
    if (stopEntry) mSel = 1;
    else if (selWr) mSel = selData;
    mPhase = mPhase + 1'b1;
    @(negedge clk);
    reloadWr = 0; selWr = 0; stopEntry = 0; irqClr = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    modelReset();
    #7 rstN = 1'b1;
    @(negedge clk);
    check("R1 count", count, 12'hFFF);
    check("R1 irq", irqFlag, 0);
    check("R1 sel", selFast, 0);

    // R9: select write
    selWr = 1; selData = 1; tick();
    check("R9 selFast", selFast, 1);
    check("R2 count after 1 clk", count, mCnt);
    run(15);
    check("R2 first step on 16th edge", count, 12'hFFE);

    // table walk
    for (int v = 0; v < NV; v++) begin
      selWr = 1; selData = VEC[v][3];
      waitMode = VEC[v][2]; stopMode = VEC[v][1]; holdExtAccess = VEC[v][0];
      run(int'(VEC[v][19:4]));
      waitMode = 0; stopMode = 0; holdExtAccess = 0;
      check($sformatf("R2/R3/R7 table %0d count", v), count, mCnt);
    end

    // R5: reload
    selWr = 1; selData = 1; tick();
    run(40);
    reloadWr = 1; tick();
    check("R5 reload", count, 12'hFFF);
    // R5: reload on a step edge
    while (mPhase[3:0] != 4'hF) tick();
    reloadWr = 1; tick();
    check("R5 reload beats step", count, 12'hFFF);

    // R4: timeout after 2048 fast steps
    while (!(mCnt == 12'h800 && mPhase[3:0] == 4'hF)) tick();
    check("R4 edge count", count, 12'h800);
    check("R4 irq before", irqFlag, 0);
    tick();
    check("R4 reload on timeout", count, 12'hFFF);
    check("R4 irq set", irqFlag, 1);

    // R8: sticky, then clear
    run(50);
    check("R8 sticky", irqFlag, 1);
    irqClr = 1; tick();
    check("R8 clear", irqFlag, 0);

    // R8: set beats clear
    while (!(mCnt == 12'h800 && mPhase[3:0] == 4'hF)) tick();
    irqClr = 1; tick();
    check("R8 set wins", irqFlag, 1);
    check("R4 count after second timeout", count, 12'hFFF);

    // R6: stop entry beats select write
    selWr = 1; selData = 0; tick();
    check("R9 sel cleared", selFast, 0);
    run(300);
    stopEntry = 1; selWr = 1; selData = 0; tick();
    check("R6 sel forced", selFast, 1);
    check("R6 reload", count, 12'hFFF);

    checks++;
    if (msbErrors != 0) begin
      errors++;
      $display("FAIL R4 msb low actual=%0d expected=0", msbErrors);
    end

    // R1: reset mid-run
    run(37);
    rstN = 0; modelReset();
    #3 rstN = 1;
    @(negedge clk);
    check("R1 count again", count, 12'hFFF);
    check("R1 irq again", irqFlag, mIrq);
    check("R1 sel again", selFast, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule